// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a TLB miss. A translation that the TLB cannot supply is handed to the walker as a 32-bit virtual address. The walker then reads two page-table entries from memory, one at each level, and returns either a refill entry for the TLB or a page-fault report. The page number of the current process's first-level table comes from a root-pointer input. The walker captures this value when it accepts a request. The virtual address is split into a 10-bit first-level index in bits 31:22, a 10-bit second-level index in bits 21:12 and a 12-bit offset in bits 11:0. Entries are four bytes wide.

The memory port is a plain read port that allows one read in flight. A read is offered with a valid/ready pair, and exactly one response beat later returns the 32-bit entry. The walker handles one miss at a time and holds its request ready low for the whole walk.

A walk ends in one of two ways. If both entries are valid and resident, the walker reports the physical page number and permission bits. If either entry marks a nonexistent page or a page held on secondary storage, the walker stops at once and reports a fault. The fault report gives the level at which the walk stopped and whether the page was swapped out or never existed.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `resp_valid` and `mem_req_valid` are 0.
- R2: The first read of a walk is at address (root page number × 4096) + 4 × virtual address bits 31:22. Bits 11:0 of the virtual address never affect a read address.
- R3: The second read is at address (first-level entry bits 31:12 × 4096) + 4 × virtual address bits 21:12.
- R4: An entry has bit 0 = valid, bit 1 = resident, bits 4:2 = permissions and bits 31:12 = page number. When both entries have bits 1:0 = 11, the walk makes exactly two reads and then returns `resp_fault`=0. In that case `resp_ppn` is the second-level entry's bits 31:12 and `resp_perm` is its bits 4:2.
- R5: A first-level entry with bit 0 = 0 ends the walk after one read. The walker then reports `resp_fault`=1, `resp_fault_lvl`=0 and `resp_swapped`=0.
- R6: A first-level entry with bit 0 = 1 and bit 1 = 0 ends the walk after one read. The walker then reports `resp_fault`=1, `resp_fault_lvl`=0 and `resp_swapped`=1.
- R7: A second-level entry that fails the same test ends the walk after two reads. The walker then reports `resp_fault`=1 and `resp_fault_lvl`=1. `resp_swapped` is 1 for valid-not-resident and 0 for invalid.
- R8: From acceptance until the result cycle, `req_ready` is 0. A `req_valid` held high in that window produces no read and no result.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address hold in the next cycle.
- R10: `resp_valid` is a one-cycle pulse. `req_ready` is 1 in the cycle after it.
- R11: Each level takes 1 + S + L cycles, where S is the number of cycles `mem_req_ready` stays low and L is the response latency counted from the accepting edge. The result appears that many cycles per level read after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_pn | input | 20 | Page number of the current first-level table |
| req_valid | input | 1 | Miss request offered |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_vaddr | input | 32 | Virtual address of the miss |
| mem_req_valid | output | 1 | Entry read offered |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Entry contents |
| resp_valid | output | 1 | Result pulse |
| resp_fault | output | 1 | Walk ended in a page fault |
| resp_fault_lvl | output | 1 | Level of the faulting entry (0 first, 1 second) |
| resp_swapped | output | 1 | Fault entry was valid but not resident |
| resp_ppn | output | 20 | Physical page number (0 on a fault) |
| resp_perm | output | 3 | Permission bits of the second-level entry |

## Verification
The result is due (1 + S + L) × n cycles after the accepting edge, where n is the number of reads: two for a good walk and for a second-level fault, one for a first-level fault. The bench's memory model produces a chosen stall S and latency L. The driver folds these into the expected cycle number for each item it queues, and the monitor checks the cycle count at the moment `resp_valid` rises. Each read address is checked on the edge where the memory accepts it. The monitor also confirms one cycle after each result that the pulse has ended and the walker is ready again.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned VA_W     = 32;
  localparam int unsigned OFF_W    = 12;
  localparam int unsigned IDX_W    = 10;
  localparam int unsigned PTE_B    = 4;
  localparam int unsigned PTE_W    = PTE_B * 8;
  localparam int unsigned PN_W     = VA_W - OFF_W;
  localparam int unsigned PERM_W   = 3;
  localparam int unsigned VLD_BIT  = 0;
  localparam int unsigned RES_BIT  = 1;
  localparam int unsigned PERM_LSB = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_L1, ST_WT_L1, ST_RD_L2, ST_WT_L2, ST_DONE, ST_FAULT
  } walk_st_t;

  // byte address of entry idx in the table whose page number is base
  function automatic logic [VA_W-1:0] entry_addr(input logic [PN_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
    return {base, {OFF_W{1'b0}}} + (VA_W'(idx) * VA_W'(PTE_B));
  endfunction

  function automatic logic [IDX_W-1:0] upper_idx(input logic [PN_W-1:0] vpn);
    return vpn[PN_W-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] lower_idx(input logic [PN_W-1:0] vpn);
    return vpn[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0]  entry,
  output logic              vld,
  output logic              res,
  output logic              usable,
  output logic [PERM_W-1:0] perm,
  output logic [PN_W-1:0]   pn
);
  logic unused_bits;
  assign unused_bits = ^entry[OFF_W-1:PERM_LSB+PERM_W];

  assign vld    = entry[VLD_BIT];
  assign res    = entry[RES_BIT];
  assign usable = vld & res;
  assign perm   = entry[PERM_LSB +: PERM_W];
  assign pn     = entry[PTE_W-1 -: PN_W];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic            sel_l2,
  input  logic [PN_W-1:0] root_pn,
  input  logic [PN_W-1:0] tbl_pn,
  input  logic [PN_W-1:0] vpn,
  output logic [VA_W-1:0] addr
);
  logic [VA_W-1:0] l1_addr, l2_addr;
  assign l1_addr = entry_addr(root_pn, upper_idx(vpn));
  assign l2_addr = entry_addr(tbl_pn, lower_idx(vpn));
  assign addr    = sel_l2 ? l2_addr : l1_addr;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PN_W-1:0]   root_pn,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [VA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              resp_valid,
  output logic              resp_fault,
  output logic              resp_fault_lvl,
  output logic              resp_swapped,
  output logic [PN_W-1:0]   resp_ppn,
  output logic [PERM_W-1:0] resp_perm
);
  walk_st_t          st_q, st_d;
  logic [PN_W-1:0]   vpn_q, root_q, tbl_q, ppn_q;
  logic [PERM_W-1:0] perm_q;
  logic              lvl_q, swp_q;

  logic              d_vld, d_res, d_ok;
  logic [PERM_W-1:0] d_perm;
  logic [PN_W-1:0]   d_pn;

  logic unused_off;
  assign unused_off = ^req_vaddr[OFF_W-1:0];

  // named events for the assertions
  logic accept_ev, l1_good_ev, l1_bad_ev, l2_good_ev, l2_bad_ev;
  assign accept_ev  = req_valid & req_ready;
  assign l1_good_ev = (st_q == ST_WT_L1) & mem_rsp_valid & d_ok;
  assign l1_bad_ev  = (st_q == ST_WT_L1) & mem_rsp_valid & ~d_ok;
  assign l2_good_ev = (st_q == ST_WT_L2) & mem_rsp_valid & d_ok;
  assign l2_bad_ev  = (st_q == ST_WT_L2) & mem_rsp_valid & ~d_ok;

  ptw_pte_decode u_dec (
    .entry(mem_rsp_data), .vld(d_vld), .res(d_res), .usable(d_ok),
    .perm(d_perm), .pn(d_pn)
  );

  ptw_addr_gen u_agen (
    .sel_l2(st_q == ST_RD_L2), .root_pn(root_q), .tbl_pn(tbl_q),
    .vpn(vpn_q), .addr(mem_req_addr)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid) st_d = ST_RD_L1;
      ST_RD_L1: if (mem_req_ready) st_d = ST_WT_L1;
      ST_WT_L1: if (mem_rsp_valid) st_d = d_ok ? ST_RD_L2 : ST_FAULT;
      ST_RD_L2: if (mem_req_ready) st_d = ST_WT_L2;
      ST_WT_L2: if (mem_rsp_valid) st_d = d_ok ? ST_DONE : ST_FAULT;
      ST_DONE:  st_d = ST_IDLE;
      ST_FAULT: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      vpn_q  <= '0;
      root_q <= '0;
      tbl_q  <= '0;
      ppn_q  <= '0;
      perm_q <= '0;
      lvl_q  <= 1'b0;
      swp_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept_ev) begin
        vpn_q  <= req_vaddr[VA_W-1:OFF_W];
        root_q <= root_pn;
      end
      if (l1_good_ev) tbl_q <= d_pn;
      if (l1_bad_ev || l2_bad_ev) begin
        lvl_q <= l2_bad_ev;
        swp_q <= d_vld & ~d_res;
      end
      if (l2_good_ev) begin
        ppn_q  <= d_pn;
        perm_q <= d_perm;
      end
    end
  end

  assign req_ready      = (st_q == ST_IDLE);
  assign mem_req_valid  = (st_q == ST_RD_L1) | (st_q == ST_RD_L2);
  assign resp_valid     = (st_q == ST_DONE) | (st_q == ST_FAULT);
  assign resp_fault     = (st_q == ST_FAULT);
  assign resp_fault_lvl = (st_q == ST_FAULT) & lvl_q;
  assign resp_swapped   = (st_q == ST_FAULT) & swp_q;
  assign resp_ppn       = (st_q == ST_DONE) ? ppn_q : '0;
  assign resp_perm      = (st_q == ST_DONE) ? perm_q : '0;

  // R8: no read is offered while a request could be taken
  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
  // R9: a stalled read holds its address
  assert_hold_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R10: result is a single pulse followed by readiness
  assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid && req_ready);
  // R4: good second-level entry yields a clean result next cycle
  assert_hit_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    l2_good_ev |=> resp_valid && !resp_fault);
  // R5/R6: bad first-level entry yields a level-0 fault next cycle
  assert_l1_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    l1_bad_ev |=> resp_valid && resp_fault && !resp_fault_lvl);
  // R7: bad second-level entry yields a level-1 fault next cycle
  assert_l2_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    l2_bad_ev |=> resp_valid && resp_fault && resp_fault_lvl);
  // R2: a walk starts with no read yet on the port
  assert_start_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |-> !mem_req_valid);
endmodule

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] root_pn = 20'h00010;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        resp_valid, resp_fault, resp_fault_lvl, resp_swapped;
  logic [19:0] resp_ppn;
  logic [2:0]  resp_perm;

  always #4 clk = ~clk;   // 125 MHz

  ptw_walker i_ptw_walker (
    .clk(clk), .rst_n(rst_n), .root_pn(root_pn),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .resp_valid(resp_valid),
    .resp_fault(resp_fault), .resp_fault_lvl(resp_fault_lvl),
    .resp_swapped(resp_swapped), .resp_ppn(resp_ppn), .resp_perm(resp_perm)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int stall_n = 0;
  int lat_n = 1;

  logic [31:0] pmem [logic [31:0]];
  logic [31:0] exp_addr_q[$];

  typedef struct {
    logic        fault;
    logic        lvl;
    logic        swp;
    logic [19:0] ppn;
    logic [2:0]  perm;
    int          due;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  always @(posedge clk) cyc++;

  // memory model
  int wcnt = 0;
  int dly = 0;
  bit pend = 0;
  logic [31:0] rsp_word = '0;
  assign mem_req_ready = mem_req_valid && (wcnt >= stall_n);
  assign mem_rsp_valid = pend && (dly == 0);
  assign mem_rsp_data  = mem_rsp_valid ? rsp_word : 32'h0;

  always @(posedge clk) begin
    if (mem_rsp_valid) pend <= 1'b0;
    else if (pend && dly != 0) dly <= dly - 1;
    if (mem_req_valid && !mem_req_ready) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (mem_req_valid && mem_req_ready) begin
      pend     <= 1'b1;
      dly      <= lat_n - 1;
      rsp_word <= rd(mem_req_addr);
      if (exp_addr_q.size() == 0)
        chk(0, "R4/R8", "unexpected read", mem_req_addr, 32'h0);
      else begin
        logic [31:0] ea;
        ea = exp_addr_q.pop_front();
        chk(mem_req_addr == ea, "R2/R3", "read address", mem_req_addr, ea);
      end
    end
  end

  // monitor
  bit prev_resp = 0;
  bit prev_stall = 0;
  logic [31:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk(mem_req_valid == 1'b1, "R9", "stalled read dropped", {31'b0, mem_req_valid}, 32'h1);
        chk(mem_req_addr == prev_addr, "R9", "stalled address moved", mem_req_addr, prev_addr);
      end
      if (prev_resp) begin
        chk(!resp_valid, "R10", "result longer than one cycle", {31'b0, resp_valid}, 32'h0);
        chk(req_ready, "R10", "not ready after result", {31'b0, req_ready}, 32'h1);
      end
      if (resp_valid) begin
        if (exp_q.size() == 0)
          chk(0, "R8", "unexpected result", 32'h1, 32'h0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(cyc == e.due, "R11", "result cycle", cyc, e.due);
          chk(resp_fault == e.fault, e.fault ? "R5/R6/R7" : "R4", "fault flag", {31'b0, resp_fault}, {31'b0, e.fault});
          if (e.fault) begin
            chk(resp_fault_lvl == e.lvl, e.lvl ? "R7" : "R5", "fault level", {31'b0, resp_fault_lvl}, {31'b0, e.lvl});
            chk(resp_swapped == e.swp, e.lvl ? "R7" : "R6", "swapped flag", {31'b0, resp_swapped}, {31'b0, e.swp});
          end else begin
            chk(resp_ppn == e.ppn, "R4", "ppn", {12'b0, resp_ppn}, {12'b0, e.ppn});
            chk(resp_perm == e.perm, "R4", "perm", {29'b0, resp_perm}, {29'b0, e.perm});
          end
        end
      end
    end
    prev_resp  = rst_n && resp_valid;
    prev_stall = rst_n && mem_req_valid && !mem_req_ready;
    prev_addr  = mem_req_addr;
  end

  // driver: build expectation independently, then offer the request
  task automatic walk(input logic [31:0] va, input bit hog);
    logic [31:0] a1, a2, e1, e2;
    exp_t e;
    int per;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    per = 1 + stall_n + lat_n;
    a1 = (32'(root_pn) << 12) | ((va >> 22) << 2);
    exp_addr_q.push_back(a1);
    e1 = rd(a1);
    e.ppn = '0; e.perm = '0; e.lvl = 0; e.swp = 0;
    if (e1[1:0] != 2'b11) begin
      e.fault = 1; e.swp = e1[0]; e.due = cyc + 1 + per;
    end else begin
      a2 = (e1 & 32'hFFFF_F000) | (((va >> 12) & 32'h3FF) << 2);
      exp_addr_q.push_back(a2);
      e2 = rd(a2);
      e.due = cyc + 1 + 2 * per;
      if (e2[1:0] != 2'b11) begin
        e.fault = 1; e.lvl = 1; e.swp = e2[0];
      end else begin
        e.fault = 0; e.ppn = e2[31:12]; e.perm = e2[4:2];
      end
    end
    exp_q.push_back(e);
    req_vaddr = va;
    req_valid = 1'b1;
    @(negedge clk);
    if (hog) begin
      req_vaddr = 32'hFFC0_0000;   // held while busy; must be ignored (R8)
      while (!resp_valid) begin
        chk(!req_ready, "R8", "ready while busy", {31'b0, req_ready}, 32'h0);
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // root table at page 0x10, second-level tables at 0x20 and 0x21
    pmem[32'h0001_0004] = 32'h0002_0017;  // idx1=1 -> table 0x20
    pmem[32'h0001_0FFC] = 32'h0002_1003;  // idx1=0x3FF -> table 0x21
    pmem[32'h0001_0008] = 32'h0003_0001;  // idx1=2 valid, not resident
    pmem[32'h0001_0000] = 32'h0002_0003;  // idx1=0 -> table 0x20
    pmem[32'h0002_000C] = 32'h1234_500B;  // good page 0x12345 perm 010
    pmem[32'h0002_1FFC] = 32'hABCDE_01F;  // good page 0xABCDE perm 111
    pmem[32'h0002_0010] = 32'h5555_5001;  // swapped data page
    pmem[32'h0002_0000] = 32'h7777_7003;  // idx2=0 good, perm 000

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", {31'b0, req_ready}, 32'h1);
    chk(resp_valid == 1'b0, "R1", "reset resp_valid", {31'b0, resp_valid}, 32'h0);
    chk(mem_req_valid == 1'b0, "R1", "reset mem_req_valid", {31'b0, mem_req_valid}, 32'h0);
    rst_n = 1'b1;

    walk(32'h0040_3ABC, 0);   // R4 good walk, R2 offset ignored
    walk(32'h0040_3000, 0);   // same page, other offset
    walk(32'hFFFF_FFFF, 0);   // R3 top indices
    walk(32'h0000_0123, 0);   // zero indices
    walk(32'h00C0_0000, 0);   // R5 missing first-level entry
    walk(32'h0080_0000, 0);   // R6 swapped first-level entry
    walk(32'h0040_4000, 0);   // R7 second-level swapped
    walk(32'h0040_5000, 0);   // R7 second-level missing
    stall_n = 2; lat_n = 3;
    walk(32'h0040_3004, 0);   // R9 R11 stalls and latency
    walk(32'h0080_0FFF, 0);
    stall_n = 1; lat_n = 2;
    walk(32'hFFFF_F000, 1);   // R8 request held while busy
    stall_n = 0; lat_n = 1;
    walk(32'h0040_4FFF, 1);
    repeat (5) @(negedge clk);
    chk(exp_addr_q.size() == 0, "R4", "reads left over", exp_addr_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule